// File: doc/BRIEF.md
# Embedded Word Boundary Serializer

This block takes 12-bit parallel words and sends them one bit at a time, together with a forwarded bit clock, so that a receiver can rebuild each word using only those two lines. A word is captured on the rising edge of a strobe and held in a one-entry buffer. At the start of the next frame it is expanded to a 14-bit frame by appending two guard bits derived from its top bit, and shifted out over 14 bit slots. Frames are placed back to back.

The block runs on the system clock and advances one slot on each cycle in which the bit-rate enable is high. The enable is expected to pulse 14 times per reference period. The forwarded clock changes level on every slot, so each slot corresponds to one edge, and data and clock change together. The end of a word is marked in the clock itself: the low level that would normally fall on the first guard slot is left out, so the clock stays high for three slots while the guard bits force a data transition. When the strobe is slower than the reference and no word is waiting, a filler frame of zeros with an ordinary clock is sent instead. A strobe that arrives while a word is still waiting raises a one-cycle overrun pulse.

Top module: `ewb_serializer`

## Requirements
- R1: A frame carries its 14 bits in slot order 0..13 as pdata[0], pdata[1], ... pdata[11], then the inverse of pdata[11] in slot 12, then pdata[11] again in slot 13. As a 14-bit value with slot 0 in the LSB, the frame is {d11, ~d11, d}, so FFF gives 2FFF and 555 gives 1555.
- R2: ser_clk is low in every even slot (0, 2, ... 10) and high in every odd slot (1, 3, ... 13). It therefore changes level on every slot from 0 through 11.
- R3: In a frame that carries a word, ser_clk is also high in slot 12, so it stays high for the three slots 11, 12 and 13. The clock pattern for such a frame, with slot 0 in the LSB, is 3AAA.
- R4: A word is taken from pdata in the cycle that a rising edge of strobe is seen. Later changes to pdata while strobe stays high have no effect. A captured word is sent in the first frame that starts after the capture.
- R5: A frame that starts with no word waiting is a filler frame. Its data is 0 in all 14 slots, and its clock follows R2 with slot 12 low (pattern 2AAA).
- R6: A strobe rising edge seen while a word is waiting, in a cycle that does not start a frame, pulses overrun high for exactly one cycle, one cycle after the edge. The new word is dropped and the waiting word is sent unchanged.
- R7: ser_data and ser_clk change only in the cycle after one in which bit_en is high. They hold their values through cycles in which bit_en is low.
- R8: After reset, ser_data is 0, ser_clk is 1 and overrun is 0. No word is waiting, and the first bit_en pulse starts slot 0 of a frame.
- R9: Each captured word is sent in exactly one frame. If no new word is captured, the frame after it is a filler frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable; each high cycle advances one slot |
| strobe | input | 1 | Word strobe; a rising edge captures pdata |
| pdata | input | 12 | Parallel word |
| ser_data | output | 1 | Serial data level for the current slot |
| ser_clk | output | 1 | Forwarded bit clock level for the current slot |
| overrun | output | 1 | One-cycle pulse when a word is dropped |

## Verification
The bench builds the block with the default word width of 12. This gives the 14-slot frame, puts the guard bits in slots 12 and 13, and makes the frame examples 2FFF and 1555 checkable bit by bit. It runs the bit enable both on every clock cycle and with two idle cycles between slots. The gapped case exercises the hold between enables, along with a strobe that arrives while a frame is already in flight. Words with only the top bit set and with the top bit clear cover both polarities of the guard pair.

// File: rtl/ewb_pkg.sv
// Shared definitions for the embedded word boundary serializer.
// Assumes the frame is the word plus two guard bits.
package ewb_pkg;
    localparam int GUARD_BITS = 2;

    // One slot of line output: data level and forwarded clock level.
    typedef struct packed {
        logic data;
        logic clk;
    } line_t;
endpackage

// File: rtl/ewb_slot_timer.sv
// Slot counter for one frame. It advances on bit_en and wraps after the
// last slot. Reset parks it on the last slot, so the first enable begins
// slot 0. Assumes FRAME_BITS is at least 2.
module ewb_slot_timer #(
    parameter int FRAME_BITS = 14,
    localparam int SLOT_W = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    output logic [SLOT_W-1:0] slot_nxt,
    output logic              take
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);

    logic [SLOT_W-1:0] slot_q;

    // Next slot index, wrapping at the frame end.
    always_comb begin
        slot_nxt = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        take     = bit_en && (slot_q == LAST_SLOT);
    end

    // Slot register, stepped by the bit enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= LAST_SLOT;
        end else if (bit_en) begin
            slot_q <= slot_nxt;
        end
    end

    // R8: slot index stays inside the frame
    assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST_SLOT);

    // R7: without an enable the slot does not move
    assert_slot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(slot_q));
endmodule

// File: rtl/ewb_word_buffer.sv
// One-entry word buffer between the strobe and the frame timing.
// Captures pdata on a rising strobe edge seen in the clk domain.
// Assumes strobe is synchronous to clk and pdata is stable when it rises.
module ewb_word_buffer #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [WORD_W-1:0] pdata,
    input  logic              take,
    output logic [WORD_W-1:0] word,
    output logic              word_ok,
    output logic              overrun
);
    logic              strobe_q;
    logic              rise;
    logic              room;
    logic [WORD_W-1:0] word_q;
    logic              pend_q;

    // Edge detect, plus whether the entry is free (empty or leaving now).
    always_comb begin
        rise = strobe && !strobe_q;
        room = !pend_q || take;
    end

    // Strobe history, buffer entry, pending flag and overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            word_q   <= '0;
            pend_q   <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            strobe_q <= strobe;
            overrun  <= rise && !room;
            if (rise && room) begin
                word_q <= pdata;
                pend_q <= 1'b1;
            end else if (take) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign word    = word_q;
    assign word_ok = pend_q;

    // R6: a dropped word leaves the waiting word and flag untouched
    assert_overrun_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && pend_q && !take) |=> (pend_q && word_q == $past(word_q)));

    // R6: an overrun pulse only appears with a word still waiting
    assert_overrun_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> pend_q);

    // R4: without a rising edge the stored word never changes
    assert_no_edge_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(word_q));
endmodule

// File: rtl/ewb_frame_shifter.sv
// Builds the 14-slot frame at each frame start and shifts it out LSB
// first. It also produces the forwarded clock level, which skips the low
// level in the first guard slot when the frame carries a word.
// Assumes FRAME_BITS is even, so the last slot is a high slot.
module ewb_frame_shifter
    import ewb_pkg::*;
#(
    parameter int WORD_W = 12,
    localparam int FRAME_BITS = WORD_W + GUARD_BITS,
    localparam int SLOT_W = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              take,
    input  logic [SLOT_W-1:0] slot_nxt,
    input  logic [WORD_W-1:0] word,
    input  logic              word_ok,
    output line_t             line
);
    localparam logic [SLOT_W-1:0] GUARD_SLOT = SLOT_W'(FRAME_BITS - GUARD_BITS);

    logic [FRAME_BITS-1:0] frame;
    logic [FRAME_BITS-1:0] load_bits;
    logic [FRAME_BITS-1:0] sr_q;
    logic                  marked_q;
    logic                  marked_nxt;
    line_t                 line_q;
    line_t                 line_nxt;

    // Frame image: the word, then the inverted top bit, then the top bit.
    always_comb begin
        frame      = {word[WORD_W-1], ~word[WORD_W-1], word};
        load_bits  = word_ok ? frame : '0;
        marked_nxt = take ? word_ok : marked_q;
    end

    // Line levels for the slot that starts at this enable.
    always_comb begin
        line_nxt.data = take ? load_bits[0] : sr_q[0];
        line_nxt.clk  = slot_nxt[0] || (marked_nxt && slot_nxt == GUARD_SLOT);
    end

    // Shift register, boundary mark and registered line outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q       <= '0;
            marked_q   <= 1'b0;
            line_q.data <= 1'b0;
            line_q.clk  <= 1'b1;
        end else if (bit_en) begin
            sr_q     <= take ? (load_bits >> 1) : (sr_q >> 1);
            marked_q <= marked_nxt;
            line_q   <= line_nxt;
        end
    end

    assign line = line_q;

    // R7: line levels hold while the enable is low
    assert_line_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_q));

    // R2: the clock changes level on every slot before the guard slot
    assert_clk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && slot_nxt < GUARD_SLOT) |=> (line_q.clk != $past(line_q.clk)));

    // R1: entering the first guard slot of a word frame flips the data
    assert_guard_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && marked_q && slot_nxt == GUARD_SLOT) |=> (line_q.data != $past(line_q.data)));

    // R5: a filler frame begins with a zero data bit
    assert_filler_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !word_ok) |=> !line_q.data);
endmodule

// File: rtl/ewb_serializer.sv
// Top of the embedded word boundary serializer. It captures a word on the
// strobe, then sends it as a 14-slot frame with a forwarded clock whose
// stretched high level marks the word end. Filler frames are sent when
// no word is waiting. Assumes bit_en pulses 14 times per reference period.
module ewb_serializer #(
    parameter int WORD_W = 12,
    localparam int FRAME_BITS = WORD_W + ewb_pkg::GUARD_BITS,
    localparam int SLOT_W = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              strobe,
    input  logic [WORD_W-1:0] pdata,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              overrun
);
    import ewb_pkg::*;

    logic [SLOT_W-1:0] slot_nxt;
    logic              take;
    logic [WORD_W-1:0] word;
    logic              word_ok;
    line_t             line;

    ewb_slot_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .slot_nxt (slot_nxt),
        .take     (take)
    );

    ewb_word_buffer #(.WORD_W(WORD_W)) u_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .pdata   (pdata),
        .take    (take),
        .word    (word),
        .word_ok (word_ok),
        .overrun (overrun)
    );

    ewb_frame_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .take     (take),
        .slot_nxt (slot_nxt),
        .word     (word),
        .word_ok  (word_ok),
        .line     (line)
    );

    assign ser_data = line.data;
    assign ser_clk  = line.clk;

    // R9: the waiting word is released at a frame start unless refilled
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && word_ok && !(strobe && !$past(strobe))) |=> !word_ok);
endmodule

// File: tb/test_ewb_serializer.sv
module test_ewb_serializer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        strobe = 1'b0;
    logic [11:0] pdata = '0;
    logic        ser_data;
    logic        ser_clk;
    logic        overrun;

    int checks = 0;
    int failures = 0;
    int gap = 0;
    int bslot = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ewb_serializer i_ewb_serializer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .strobe(strobe),
        .pdata(pdata), .ser_data(ser_data), .ser_clk(ser_clk), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One slot: pulse bit_en, sample after the edge, then idle gap cycles.
    task automatic step(output logic d, output logic c);
        bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0;
        d = ser_data;
        c = ser_clk;
        for (int g = 0; g < gap; g++) begin
            @(posedge clk);
            @(negedge clk);
            chk(ser_data == d && ser_clk == c, "R7 hold", {ser_data, ser_clk}, {d, c});
        end
        bslot = (bslot + 1) % 14;
    endtask

    // Strobe for one cycle; returns overrun as seen one cycle after the edge.
    task automatic send_word(input logic [11:0] w, output logic ov);
        strobe = 1'b1;
        pdata = w;
        @(posedge clk);
        @(negedge clk);
        strobe = 1'b0;
        pdata = ~w;
        ov = overrun;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Run one whole frame; optionally strobe mid_word after slot 5.
    task automatic check_frame(input string tag, input bit valid, input logic [11:0] w,
                               input bit mid, input logic [11:0] mid_word);
        logic [13:0] dv, cv, ed, ec;
        logic d, c, ov;
        dv = '0;
        cv = '0;
        for (int s = 0; s < 14; s++) begin
            step(d, c);
            dv[s] = d;
            cv[s] = c;
            if (mid && s == 5) begin
                send_word(mid_word, ov);
                chk(ov == 1'b0, "R4 mid-frame capture no overrun", {15'd0, ov}, 16'd0);
            end
        end
        ed = valid ? {w[11], ~w[11], w} : 14'h0000;
        ec = valid ? 14'h3AAA : 14'h2AAA;
        chk(dv == ed, {tag, " data"}, {2'b0, dv}, {2'b0, ed});
        chk(cv == ec, {tag, " clock"}, {2'b0, cv}, {2'b0, ec});
    endtask

    task automatic t_reset();
        chk(ser_data == 1'b0, "R8 reset data", {15'd0, ser_data}, 16'd0);
        chk(ser_clk == 1'b1, "R8 reset clock", {15'd0, ser_clk}, 16'd1);
        chk(overrun == 1'b0, "R8 reset overrun", {15'd0, overrun}, 16'd0);
        check_frame("R8 first frame is filler", 1'b0, 12'h000, 1'b0, 12'h000);
    endtask

    task automatic t_basic();
        logic ov;
        send_word(12'hFFF, ov);
        chk(ov == 1'b0, "R6 no overrun on free buffer", {15'd0, ov}, 16'd0);
        check_frame("R1 R3 word FFF", 1'b1, 12'hFFF, 1'b0, 12'h0);
        send_word(12'h555, ov);
        check_frame("R1 R3 word 555", 1'b1, 12'h555, 1'b0, 12'h0);
        check_frame("R5 R9 filler after word", 1'b0, 12'h0, 1'b0, 12'h0);
    endtask

    task automatic t_polarity();
        logic ov;
        send_word(12'h800, ov);
        check_frame("R1 word 800", 1'b1, 12'h800, 1'b0, 12'h0);
        send_word(12'h7FF, ov);
        check_frame("R1 word 7FF", 1'b1, 12'h7FF, 1'b0, 12'h0);
    endtask

    task automatic t_back_to_back();
        logic ov;
        send_word(12'h3C5, ov);
        check_frame("R4 in-flight frame 3C5", 1'b1, 12'h3C5, 1'b1, 12'hA5A);
        check_frame("R4 word captured mid-frame A5A", 1'b1, 12'hA5A, 1'b0, 12'h0);
        check_frame("R9 filler after A5A", 1'b0, 12'h0, 1'b0, 12'h0);
    endtask

    task automatic t_overrun();
        logic ov1, ov2;
        send_word(12'h123, ov1);
        send_word(12'h456, ov2);
        chk(ov1 == 1'b0, "R6 first strobe no overrun", {15'd0, ov1}, 16'd0);
        chk(ov2 == 1'b1, "R6 second strobe overrun", {15'd0, ov2}, 16'd1);
        chk(overrun == 1'b0, "R6 overrun one cycle", {15'd0, overrun}, 16'd0);
        check_frame("R6 waiting word kept 123", 1'b1, 12'h123, 1'b0, 12'h0);
        check_frame("R6 R9 dropped word not sent", 1'b0, 12'h0, 1'b0, 12'h0);
    endtask

    task automatic t_held_strobe();
        strobe = 1'b1;
        pdata = 12'h6B2;
        @(posedge clk);
        @(negedge clk);
        pdata = 12'h19D;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        strobe = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_frame("R4 held strobe keeps first data", 1'b1, 12'h6B2, 1'b0, 12'h0);
    endtask

    task automatic t_gapped();
        logic ov;
        gap = 2;
        send_word(12'h0F0, ov);
        check_frame("R7 gapped word 0F0", 1'b1, 12'h0F0, 1'b1, 12'h9C3);
        check_frame("R7 gapped word 9C3", 1'b1, 12'h9C3, 1'b0, 12'h0);
        check_frame("R7 gapped filler", 1'b0, 12'h0, 1'b0, 12'h0);
        gap = 0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 1000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_polarity();
        t_back_to_back();
        t_overrun();
        t_held_strobe();
        t_gapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule